// File: doc/BRIEF.md
# Serial Character Receiver with Status Word

This block receives asynchronous serial characters of eight data bits with no parity and one stop bit. A clock-enable tick at sixteen times the bit rate paces the sampler. A falling edge on an idle line is confirmed as a start bit half a bit later. Each following bit is then sampled at its centre, least significant bit first. The last completed character is kept in a read word, together with error, overrun, framing and line-break flags. Software reads that word whenever it likes. A one-cycle read strobe tells the block that the buffer has been consumed.

A maintenance control switches the receive path from the external serial pin to the local transmitter's serial output, so the serial channel can test itself. A separate break-detect output reports a long SPACE condition to logic outside the block. It stays asserted until the buffer is read. An active-low power-up reset and a synchronous bus-initialise pulse both return the block to its idle, cleared state.

Top module: `sline_rx`

## Requirements
- R1: A frame is one SPACE (0) start bit, 8 data bits sent LSB first, and one stop bit. Each bit lasts 16 `tick` pulses. The received byte appears in `rd_word[7:0]` once the stop bit has been sampled.
- R2: `rd_word[14]` (overrun) is set when a character completes while the previous character is still unread. A character is unread when it completed after the last `rd_stb`.
- R3: `rd_word[13]` (framing) is set when the stop bit of the completed character is sampled as SPACE.
- R4: `rd_word[15]` always equals the OR of `rd_word[14]` and `rd_word[13]`.
- R5: Bits 15, 14 and 13 change only when a character completes, a reset occurs or `bus_init` pulses. Each completion rewrites them from that character alone. A read strobe leaves them as they are.
- R6: `rd_word[11]` sets after the line has been SPACE at every sample point of a whole frame plus one further bit time, 11 bit times in all. It clears once the line returns to MARK (1).
- R7: `brk_det` asserts on the same condition as R6. It stays asserted until `rd_stb` pulses, whatever the line does.
- R8: While `loop_en` is 1, `txd_loop` is the receive input and `rxd_ext` has no effect.
- R9: After reset, and one cycle after a `bus_init` pulse, `rd_word` reads 0 and `brk_det` is 0. Bits 31:16, 12 and 10:8 of `rd_word` are always 0.
- R10: A SPACE pulse shorter than half a bit time on an idle line is rejected and does not produce a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| bus_init | input | 1 | Synchronous clear pulse, same effect as reset |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd_ext | input | 1 | External serial input (1 = MARK) |
| txd_loop | input | 1 | Local transmitter serial output, used in maintenance mode |
| loop_en | input | 1 | Maintenance loopback select |
| rd_stb | input | 1 | One-cycle strobe marking a read of the receive word |
| rd_word | output | 32 | Received byte and status flags |
| brk_det | output | 1 | Break recognition, held until read |

## Verification
The properties assume that `rd_stb` and `bus_init` are single-cycle pulses synchronous to `clk`. They also assume the serial input changes only at whole bit-time boundaries, apart from the deliberate short glitch. The bench derives `tick` from a fixed divider and drives every line bit for exactly 16 ticks. It issues reads only after a character has completed, and it drops the break line back to MARK only after the extra bit time has passed. This keeps the stimulus inside the assumed input envelope.

// File: rtl/sline_rx.sv
module sline_rx #(
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_init,
  input  logic        tick,
  input  logic        rxd_ext,
  input  logic        txd_loop,
  input  logic        loop_en,
  input  logic        rd_stb,
  output logic [31:0] rd_word,
  output logic        brk_det
);
  localparam int DW   = 8;
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DW);
  localparam int HALF = OSR / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_EXTRA, S_HUNT} st_t;

  st_t           state;
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shift, data_q;
  logic          allz, valid_q, ovr_q, frm_q, brk_q;

  wire line_in = loop_en ? txd_loop : rxd_ext;
  wire rx_s    = sync_q[1];
  wire ctr_end = (cnt == CW'(OSR - 1));
  wire done    = tick && (state == S_STOP) && ctr_end;
  wire brk_set = tick && (state == S_EXTRA) && ctr_end && !rx_s;

  assign rd_word = {16'h0, ovr_q | frm_q, ovr_q, frm_q, 1'b0, brk_q, 3'b000, data_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], line_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shift <= '0;
      allz  <= 1'b0;
    end else if (bus_init) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shift <= '0;
      allz  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (tick && !rx_s) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: if (tick) begin
          if (cnt == CW'(HALF)) begin
            cnt  <= '0;
            bitn <= '0;
            allz <= 1'b1;
            state <= rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (tick) begin
          if (ctr_end) begin
            cnt   <= '0;
            shift <= {rx_s, shift[DW-1:1]};
            allz  <= allz & !rx_s;
            if (bitn == BW'(DW - 1)) state <= S_STOP;
            else bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: if (tick) begin
          if (ctr_end) begin
            cnt <= '0;
            if (rx_s)      state <= S_IDLE;
            else if (allz) state <= S_EXTRA;
            else           state <= S_HUNT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_EXTRA: if (tick) begin
          if (ctr_end) begin
            cnt   <= '0;
            state <= rx_s ? S_IDLE : S_HUNT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HUNT: if (rx_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      frm_q   <= 1'b0;
      brk_q   <= 1'b0;
      brk_det <= 1'b0;
    end else if (bus_init) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      frm_q   <= 1'b0;
      brk_q   <= 1'b0;
      brk_det <= 1'b0;
    end else begin
      if (done) begin
        data_q  <= shift;
        frm_q   <= !rx_s;
        ovr_q   <= valid_q && !rd_stb;
        valid_q <= 1'b1;
      end else if (rd_stb) begin
        valid_q <= 1'b0;
      end
      if (brk_set)                    brk_q <= 1'b1;
      else if (state == S_HUNT && rx_s) brk_q <= 1'b0;
      if (brk_set)     brk_det <= 1'b1;
      else if (rd_stb) brk_det <= 1'b0;
    end
  end
endmodule

// File: rtl/sline_rx_chk.sv
module sline_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_init,
  input logic rd_stb,
  input logic done,
  input logic valid,
  input logic rx_s,
  input logic err,
  input logic ovr,
  input logic frm,
  input logic rbrk,
  input logic brk_det
);
  p_ovr_on_unread_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid && !rd_stb && !bus_init) |=> ovr);

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !bus_init) |=> ({err, ovr, frm} == $past({err, ovr, frm})));

  p_brk_mark_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rbrk && rx_s && !bus_init) |=> !rbrk);

  p_brkdet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && !rd_stb && !bus_init) |=> brk_det);

  p_init_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> (!err && !ovr && !frm && !rbrk && !brk_det));

  p_brkdet_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && brk_det && !bus_init) |=> (!brk_det || $rose(rbrk)));
endmodule

bind sline_rx sline_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .rd_stb(rd_stb),
  .done(done), .valid(valid_q), .rx_s(rx_s),
  .err(rd_word[15]), .ovr(rd_word[14]), .frm(rd_word[13]), .rbrk(rd_word[11]),
  .brk_det(brk_det)
);

// File: tb/sline_rx_tb.sv
module sline_rx_tb;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_init = 1'b0, tick = 1'b0, rxd_ext = 1'b1, txd_loop = 1'b1;
  logic loop_en = 1'b0, rd_stb = 1'b0;
  logic [31:0] rd_word;
  logic brk_det;
  int checks = 0, fails = 0, cyc = 0, tdc = 0;

  always #2.5 clk = ~clk;

  sline_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .tick(tick),
    .rxd_ext(rxd_ext), .txd_loop(txd_loop), .loop_en(loop_en), .rd_stb(rd_stb),
    .rd_word(rd_word), .brk_det(brk_det)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tdc <= (tdc == TDIV - 1) ? 0 : tdc + 1;
  end
  always @(negedge clk) tick = (tdc == 0);

  // field order per row: data[25:18], stop bit[17], read after[16], expected word[15:0]
  localparam logic [25:0] VEC [0:5] = '{
    {8'h55, 1'b1, 1'b1, 16'h0055},
    {8'hA3, 1'b1, 1'b0, 16'h00A3},
    {8'h0F, 1'b1, 1'b1, 16'hC00F},
    {8'h81, 1'b0, 1'b1, 16'hA081},
    {8'hFF, 1'b1, 1'b1, 16'h00FF},
    {8'h00, 1'b1, 1'b1, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic v, input bit lp, input int n);
    if (lp) txd_loop = v; else rxd_ext = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic stopb, input bit lp);
    put(1'b0, lp, BITC);
    for (int i = 0; i < 8; i++) put(d[i], lp, BITC);
    put(stopb, lp, BITC);
    put(1'b1, lp, 8);
  endtask

  task automatic read_pulse();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rd_word == 32'h0 && brk_det == 1'b0, "R9 reset state", {rd_word[31:1], brk_det}, 32'h0);
    rst_n = 1'b1;
    repeat (BITC) @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      send(VEC[k][25:18], VEC[k][17], 1'b0);
      chk(rd_word == {16'h0, VEC[k][15:0]}, "R1 R2 R3 R4 R5 table", rd_word, {16'h0, VEC[k][15:0]});
      if (VEC[k][16]) read_pulse();
      repeat (BITC) @(negedge clk);
    end
    chk(rd_word == 32'h0, "R5 read leaves flags", rd_word, 32'h0);

    put(1'b0, 1'b0, 3 * TDIV);
    put(1'b1, 1'b0, 2 * BITC);
    chk(rd_word == 32'h0, "R10 glitch ignored", rd_word, 32'h0);
    send(8'h96, 1'b1, 1'b0);
    chk(rd_word == 32'h0096, "R10 next char no overrun", rd_word, 32'h0096);
    read_pulse();

    put(1'b0, 1'b0, 12 * BITC);
    chk(rd_word == 32'hA800, "R6 break flag set", rd_word, 32'hA800);
    chk(brk_det == 1'b1, "R7 break output set", {31'h0, brk_det}, 32'h1);
    put(1'b1, 1'b0, 8);
    chk(rd_word == 32'hA000, "R6 mark clears break flag", rd_word, 32'hA000);
    chk(brk_det == 1'b1, "R7 break output held after mark", {31'h0, brk_det}, 32'h1);
    read_pulse();
    chk(brk_det == 1'b0, "R7 read clears break output", {31'h0, brk_det}, 32'h0);
    chk(rd_word == 32'hA000, "R5 flags kept across read", rd_word, 32'hA000);

    repeat (BITC) @(negedge clk);
    put(1'b0, 1'b0, 12 * BITC);
    put(1'b1, 1'b0, 8);
    bus_init = 1'b1;
    @(negedge clk);
    bus_init = 1'b0;
    chk(rd_word == 32'h0 && brk_det == 1'b0, "R9 bus_init clears", {rd_word[31:1], brk_det}, 32'h0);

    repeat (BITC) @(negedge clk);
    rxd_ext = 1'b0;
    loop_en = 1'b1;
    repeat (BITC) @(negedge clk);
    send(8'h3C, 1'b1, 1'b1);
    chk(rd_word == 32'h003C, "R8 loopback char", rd_word, 32'h003C);
    repeat (12 * BITC) @(negedge clk);
    chk(rd_word == 32'h003C && brk_det == 1'b0, "R8 external space ignored", rd_word, 32'h003C);
    read_pulse();
    loop_en = 1'b0;
    rxd_ext = 1'b1;
    repeat (BITC) @(negedge clk);
    send(8'hE7, 1'b1, 1'b0);
    chk(rd_word == 32'h00E7, "R1 external path restored", rd_word, 32'h00E7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule